// File: doc/BRIEF.md
# Multiplexed Micropacket Stream Reassembler

This block takes a stream of 32-bit micropacket words in which up to four transport streams are interleaved. Each word carries a tag that names its stream, a 3-bit sequence count, a packet-start flag, a device overflow flag and up to three payload bytes. For every stream the block rebuilds 188-byte transport packets from 63 fragments. It also marks the first byte of each packet and the final byte of every group of 21 completed packets.

Words enter on a valid/ready handshake. An accepted word is checked against its stream's context: whether a packet is in progress, its fragment index, its packet index and its last sequence value. The payload bytes are then sent out one per cycle on that stream's byte lane. Sequence gaps and device overflow flags raise one-cycle event pulses on the stream they belong to. Each stream has an enable input. While the enable is low the stream ignores its words and its context stays cleared, so raising the enable starts the stream from a fresh state.

Top module: `mpkt_reassembler`

## Requirements
- R1: The tag field is bits 31:29. A tag value k from 1 to NUM_STREAMS selects stream k-1. Any other tag value makes the word ignored: it produces no byte and no event.
- R2: While a stream's enable is low, words for that stream are ignored. Its fragment index, packet index and sequence history are held cleared, so once the enable is high again a non-start word is dropped and the next word's sequence value is not compared.
- R3: Bit 25 set marks a start fragment. It sets the stream's fragment index to zero, abandoning any partial packet, and the first byte it produces is flagged with out_sop.
- R4: A stream with no packet in progress drops every word whose bit 25 is clear, producing no byte and no event.
- R5: An accepted fragment emits its payload one byte per cycle on its stream's lane: bits 23:16 first, then 15:8, then 7:0. The first byte appears in the cycle after acceptance, and the following bytes appear in consecutive cycles.
- R6: A packet is 63 fragments long. The 63rd fragment emits only its bits 23:16 and 15:8, which makes 188 bytes. After that the stream has no packet in progress.
- R7: The sequence field is bits 28:26. When a word accepted by a stream carries a value other than the stream's previous value plus one modulo 8, loss_evt for that stream pulses for one cycle, in the cycle after acceptance. The first word after reset or after enabling is not compared.
- R8: When bit 24 is set on a word that a stream accepts, ovf_evt for that stream pulses for one cycle, in the cycle after acceptance.
- R9: out_batch is raised together with the final byte of every 21st completed packet. Each stream keeps its own packet count.
- R10: in_ready is high whenever no byte is pending, and also in the cycle that emits an accepted word's final byte. At most one out_valid bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A micropacket word is offered |
| in_ready | output | 1 | The block takes the offered word at this edge |
| in_word | input | 32 | Micropacket word |
| stream_en | input | NUM_STREAMS | Per-stream enable |
| out_valid | output | NUM_STREAMS | Byte present on a stream lane |
| out_data | output | 8*NUM_STREAMS | Byte lanes, stream i at bits 8i+7:8i |
| out_sop | output | NUM_STREAMS | First byte of a packet |
| out_batch | output | NUM_STREAMS | Final byte of a 21-packet batch |
| loss_evt | output | NUM_STREAMS | Sequence gap pulse |
| ovf_evt | output | NUM_STREAMS | Device overflow pulse |

## Verification
The properties assume the block is reset before the first word and that in_word and stream_en hold known values. Stimulus changes only on falling clock edges. The bench holds each word until it is accepted, and it changes an enable only when no word is being offered. Under these conditions the properties on ignored tags and disabled streams can treat a word as having an effect only in the single cycle after it is accepted. The directed tasks restart a stream through its enable before reusing it, so each scenario begins from a known context.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;

   // Field layout of one incoming micropacket word (bit 31 down to bit 0).
   typedef struct packed {
      logic [2:0]  tag;      // stream number plus one
      logic [2:0]  seq;      // modulo-8 sequence count
      logic        start;    // first fragment of a packet
      logic        ovf;      // device-side overflow flag
      logic [23:0] payload;  // up to three bytes, most significant first
   } mpkt_word_t;

   localparam int unsigned TAG_W   = 3;
   localparam int unsigned SEQ_W   = 3;
   localparam int unsigned FRAG_BYTES = 3;

endpackage

// File: rtl/mpkt_stream_ctx.sv
module mpkt_stream_ctx
   import mpkt_pkg::*;
#(
   parameter int unsigned STREAM_IDX = 0,
   parameter int unsigned FRAGS_PER_PKT = 63,
   parameter int unsigned PKTS_PER_BATCH = 21
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       acc,
   input  mpkt_word_t word,
   output logic       take,
   output logic       sop,
   output logic       last_frag,
   output logic       batch_end,
   output logic       loss_evt,
   output logic       ovf_evt
);

   localparam int unsigned FW = $clog2(FRAGS_PER_PKT);
   localparam int unsigned PW = $clog2(PKTS_PER_BATCH);
   localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(STREAM_IDX + 1);
   localparam logic [FW-1:0] FRAG_LAST = FW'(FRAGS_PER_PKT - 1);
   localparam logic [PW-1:0] PKT_LAST  = PW'(PKTS_PER_BATCH - 1);

   logic [FW-1:0]    frag_q;
   logic [PW-1:0]    pkt_q;
   logic [SEQ_W-1:0] seq_q;
   logic             seq_known_q;

   logic             hit;
   logic             in_pkt;
   logic [FW-1:0]    frag_now;
   logic             seq_gap;

   always_comb begin
      hit       = acc && en && (word.tag == MY_TAG);
      in_pkt    = (frag_q != '0);
      take      = hit && (word.start || in_pkt);
      frag_now  = word.start ? '0 : frag_q;
      sop       = (frag_now == '0);
      last_frag = (frag_now == FRAG_LAST);
      batch_end = last_frag && (pkt_q == PKT_LAST);
      seq_gap   = seq_known_q && (word.seq != SEQ_W'(seq_q + 1'b1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         frag_q      <= '0;
         pkt_q       <= '0;
         seq_q       <= '0;
         seq_known_q <= 1'b0;
         loss_evt    <= 1'b0;
         ovf_evt     <= 1'b0;
      end else begin
         loss_evt <= take && seq_gap;
         ovf_evt  <= take && word.ovf;
         if (take) begin
            frag_q      <= last_frag ? '0 : FW'(frag_now + 1'b1);
            seq_q       <= word.seq;
            seq_known_q <= 1'b1;
            if (last_frag) begin
               pkt_q <= batch_end ? '0 : PW'(pkt_q + 1'b1);
            end
         end
      end
   end

endmodule

// File: rtl/mpkt_serializer.sv
module mpkt_serializer
   import mpkt_pkg::*;
#(
   parameter int unsigned NUM_STREAMS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [NUM_STREAMS-1:0] load_lane,
   input  logic [23:0]            load_data,
   input  logic                   load_short,
   input  logic                   load_sop,
   input  logic                   load_batch,
   output logic                   ready,
   output logic [NUM_STREAMS-1:0] lane_valid,
   output logic [7:0]             byte_o,
   output logic                   sop_o,
   output logic                   batch_o
);

   localparam int unsigned IW = $clog2(FRAG_BYTES);

   logic                   busy_q;
   logic [NUM_STREAMS-1:0] lane_q;
   logic [23:0]            data_q;
   logic [IW-1:0]          idx_q;
   logic                   short_q;
   logic                   sop_q;
   logic                   batch_q;
   logic                   final_byte;

   always_comb begin
      final_byte = busy_q && (idx_q == (short_q ? IW'(FRAG_BYTES - 2) : IW'(FRAG_BYTES - 1)));
      ready      = !busy_q || final_byte;
      lane_valid = busy_q ? lane_q : '0;
      sop_o      = busy_q && sop_q && (idx_q == '0);
      batch_o    = batch_q && final_byte;
      case (idx_q)
         IW'(0):  byte_o = data_q[23:16];
         IW'(1):  byte_o = data_q[15:8];
         default: byte_o = data_q[7:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         lane_q  <= '0;
         data_q  <= '0;
         idx_q   <= '0;
         short_q <= 1'b0;
         sop_q   <= 1'b0;
         batch_q <= 1'b0;
      end else if (load) begin
         busy_q  <= 1'b1;
         lane_q  <= load_lane;
         data_q  <= load_data;
         idx_q   <= '0;
         short_q <= load_short;
         sop_q   <= load_sop;
         batch_q <= load_batch;
      end else if (final_byte) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         idx_q <= IW'(idx_q + 1'b1);
      end
   end

endmodule

// File: rtl/mpkt_lane_fan.sv
module mpkt_lane_fan #(
   parameter int unsigned NUM_STREAMS = 4
) (
   input  logic [NUM_STREAMS-1:0]   lane_valid,
   input  logic [7:0]               byte_i,
   input  logic                     sop_i,
   input  logic                     batch_i,
   output logic [NUM_STREAMS-1:0]   out_valid,
   output logic [8*NUM_STREAMS-1:0] out_data,
   output logic [NUM_STREAMS-1:0]   out_sop,
   output logic [NUM_STREAMS-1:0]   out_batch
);

   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_lane
      assign out_valid[g]       = lane_valid[g];
      assign out_data[8*g +: 8] = lane_valid[g] ? byte_i : 8'h00;
      assign out_sop[g]         = lane_valid[g] && sop_i;
      assign out_batch[g]       = lane_valid[g] && batch_i;
   end

endmodule

// File: rtl/mpkt_reassembler.sv
module mpkt_reassembler
   import mpkt_pkg::*;
#(
   parameter int unsigned NUM_STREAMS = 4,
   parameter int unsigned FRAGS_PER_PKT = 63,
   parameter int unsigned PKTS_PER_BATCH = 21
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [31:0]              in_word,
   input  logic [NUM_STREAMS-1:0]   stream_en,
   output logic [NUM_STREAMS-1:0]   out_valid,
   output logic [8*NUM_STREAMS-1:0] out_data,
   output logic [NUM_STREAMS-1:0]   out_sop,
   output logic [NUM_STREAMS-1:0]   out_batch,
   output logic [NUM_STREAMS-1:0]   loss_evt,
   output logic [NUM_STREAMS-1:0]   ovf_evt
);

   localparam int unsigned MAX_STREAMS = (1 << TAG_W) - 1;

   if (NUM_STREAMS < 1 || NUM_STREAMS > MAX_STREAMS) begin : g_bad_streams
      $error("NUM_STREAMS must fit the tag field");
   end
   if (FRAGS_PER_PKT < 2) begin : g_bad_frags
      $error("FRAGS_PER_PKT must be at least 2");
   end
   if (PKTS_PER_BATCH < 2) begin : g_bad_batch
      $error("PKTS_PER_BATCH must be at least 2");
   end

   mpkt_word_t             word;
   logic                   acc;
   logic [NUM_STREAMS-1:0] take;
   logic [NUM_STREAMS-1:0] sop_v;
   logic [NUM_STREAMS-1:0] last_v;
   logic [NUM_STREAMS-1:0] batch_v;

   logic                   ser_ready;
   logic [NUM_STREAMS-1:0] lane_valid;
   logic [7:0]             ser_byte;
   logic                   ser_sop;
   logic                   ser_batch;

   assign word     = mpkt_word_t'(in_word);
   assign in_ready = ser_ready;
   assign acc      = in_valid && ser_ready;

   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
      mpkt_stream_ctx #(
         .STREAM_IDX     (g),
         .FRAGS_PER_PKT  (FRAGS_PER_PKT),
         .PKTS_PER_BATCH (PKTS_PER_BATCH)
      ) u_ctx (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (stream_en[g]),
         .acc       (acc),
         .word      (word),
         .take      (take[g]),
         .sop       (sop_v[g]),
         .last_frag (last_v[g]),
         .batch_end (batch_v[g]),
         .loss_evt  (loss_evt[g]),
         .ovf_evt   (ovf_evt[g])
      );
   end

   mpkt_serializer #(
      .NUM_STREAMS (NUM_STREAMS)
   ) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (|take),
      .load_lane  (take),
      .load_data  (word.payload),
      .load_short (|(take & last_v)),
      .load_sop   (|(take & sop_v)),
      .load_batch (|(take & batch_v)),
      .ready      (ser_ready),
      .lane_valid (lane_valid),
      .byte_o     (ser_byte),
      .sop_o      (ser_sop),
      .batch_o    (ser_batch)
   );

   mpkt_lane_fan #(
      .NUM_STREAMS (NUM_STREAMS)
   ) u_fan (
      .lane_valid (lane_valid),
      .byte_i     (ser_byte),
      .sop_i      (ser_sop),
      .batch_i    (ser_batch),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_sop    (out_sop),
      .out_batch  (out_batch)
   );

endmodule

// File: rtl/mpkt_reassembler_chk.sv
module mpkt_reassembler_chk #(
   parameter int unsigned NUM_STREAMS = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic [31:0]              in_word,
   input logic [NUM_STREAMS-1:0]   stream_en,
   input logic [NUM_STREAMS-1:0]   out_valid,
   input logic [NUM_STREAMS-1:0]   out_sop,
   input logic [NUM_STREAMS-1:0]   out_batch,
   input logic [NUM_STREAMS-1:0]   loss_evt,
   input logic [NUM_STREAMS-1:0]   ovf_evt
);

   logic       acc;
   logic [2:0] tag;
   logic       bad_tag;
   logic       off_tag;

   always_comb begin
      acc     = in_valid && in_ready;
      tag     = in_word[31:29];
      bad_tag = (tag == 3'd0) || (32'(tag) > NUM_STREAMS);
      off_tag = 1'b0;
      for (int i = 0; i < NUM_STREAMS; i++) begin
         if (32'(tag) == i + 1 && !stream_en[i]) off_tag = 1'b1;
      end
   end

   // R10: a single lane carries a byte at any time
   p_one_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));

   // R10: with nothing pending the block takes words
   p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == '0) |-> in_ready);

   // R1: a word with an unused tag leaves no trace
   p_bad_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && bad_tag) |=> (out_valid == '0 && loss_evt == '0 && ovf_evt == '0));

   // R2: a word for a disabled stream leaves no trace
   p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && off_tag) |=> (out_valid == '0 && loss_evt == '0 && ovf_evt == '0));

   // R3: the start marker rides on a lane byte
   p_sop_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_sop & ~out_valid) == '0));

   // R9: the batch marker rides on a lane byte
   p_batch_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_batch & ~out_valid) == '0));

   // R8: overflow pulses follow an accepted word
   p_ovf_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt != '0) |-> $past(acc));

   // R5: bytes of one fragment come on consecutive cycles on the same lane
   p_byte_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid != '0 && !in_ready) |=> (out_valid == $past(out_valid)));

endmodule

bind mpkt_reassembler mpkt_reassembler_chk #(
   .NUM_STREAMS (NUM_STREAMS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_word   (in_word),
   .stream_en (stream_en),
   .out_valid (out_valid),
   .out_sop   (out_sop),
   .out_batch (out_batch),
   .loss_evt  (loss_evt),
   .ovf_evt   (ovf_evt)
);

// File: tb/tb_mpkt_reassembler.sv
module tb_mpkt_reassembler;

   localparam int NS = 4;
   localparam int LOGD = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [31:0]   in_word = '0;
   logic [NS-1:0] stream_en = '1;
   logic [NS-1:0] out_valid;
   logic [8*NS-1:0] out_data;
   logic [NS-1:0] out_sop;
   logic [NS-1:0] out_batch;
   logic [NS-1:0] loss_evt;
   logic [NS-1:0] ovf_evt;

   always #2.5 clk = ~clk;

   mpkt_reassembler dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .stream_en(stream_en), .out_valid(out_valid),
      .out_data(out_data), .out_sop(out_sop), .out_batch(out_batch),
      .loss_evt(loss_evt), .ovf_evt(ovf_evt)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [7:0] logb [NS][LOGD];
   int cap_n [NS];
   int sop_cnt [NS];
   int batch_cnt [NS];
   int batch_pos [NS];
   int loss_cnt [NS];
   int ovf_cnt [NS];
   logic [2:0] sq [NS];

   initial begin
      for (int i = 0; i < NS; i++) begin
         cap_n[i] = 0; sop_cnt[i] = 0; batch_cnt[i] = 0; batch_pos[i] = -1;
         loss_cnt[i] = 0; ovf_cnt[i] = 0; sq[i] = '0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = 0; i < NS; i++) begin
            if (out_valid[i]) begin
               logb[i][cap_n[i] % LOGD] = out_data[8*i +: 8];
               if (out_sop[i]) sop_cnt[i]++;
               if (out_batch[i]) begin
                  batch_cnt[i]++;
                  batch_pos[i] = cap_n[i];
               end
               cap_n[i]++;
            end
            if (loss_evt[i]) loss_cnt[i]++;
            if (ovf_evt[i]) ovf_cnt[i]++;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   function automatic logic [31:0] mkw(input int tag, input logic [2:0] s,
                                       input logic st, input logic ov,
                                       input logic [23:0] pl);
      return {tag[2:0], s, st, ov, pl};
   endfunction

   // called at a falling edge, returns at the falling edge after acceptance
   task automatic send(input logic [31:0] w);
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic frag(input int s, input logic st, input logic ov, input logic [23:0] pl);
      send(mkw(s + 1, sq[s], st, ov, pl));
      sq[s] = sq[s] + 3'd1;
   endtask

   task automatic drain();
      repeat (6) @(negedge clk);
   endtask

   task automatic restart(input int s);
      stream_en[s] = 1'b0;
      @(negedge clk);
      stream_en[s] = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R10 reset out_valid", int'(out_valid), 0);
      chk("R10 reset in_ready", int'(in_ready), 1);
      chk("R7 reset loss", int'(loss_evt), 0);
   endtask

   task automatic t_ready();
      restart(0);
      frag(0, 1'b1, 1'b0, 24'h010203);
      chk("R10 ready low on byte 0", int'(in_ready), 0);
      chk("R5 lane 0 valid on byte 0", int'(out_valid), 1);
      @(negedge clk);
      chk("R10 ready low on byte 1", int'(in_ready), 0);
      @(negedge clk);
      chk("R10 ready high on final byte", int'(in_ready), 1);
      @(negedge clk);
      chk("R10 idle after fragment", int'(out_valid), 0);
      drain();
   endtask

   task automatic t_bytes();
      int b, sp;
      restart(0);
      b = cap_n[0]; sp = sop_cnt[0];
      frag(0, 1'b1, 1'b0, 24'hA1B2C3);
      drain();
      chk("R5 byte count", cap_n[0] - b, 3);
      chk("R5 first byte bits 23:16", int'(logb[0][b % LOGD]), 'hA1);
      chk("R5 second byte bits 15:8", int'(logb[0][(b + 1) % LOGD]), 'hB2);
      chk("R5 third byte bits 7:0", int'(logb[0][(b + 2) % LOGD]), 'hC3);
      chk("R3 sop on start fragment", sop_cnt[0] - sp, 1);
   endtask

   task automatic t_tags();
      int b[NS], l, o;
      restart(1);
      for (int i = 0; i < NS; i++) b[i] = cap_n[i];
      l = loss_cnt[0] + loss_cnt[1]; o = ovf_cnt[0] + ovf_cnt[1];
      send(mkw(0, 3'd0, 1'b1, 1'b1, 24'h111111));
      send(mkw(5, 3'd0, 1'b1, 1'b1, 24'h222222));
      send(mkw(6, 3'd0, 1'b1, 1'b1, 24'h333333));
      send(mkw(7, 3'd0, 1'b1, 1'b1, 24'h444444));
      drain();
      chk("R1 unused tags give no bytes",
          (cap_n[0]-b[0])+(cap_n[1]-b[1])+(cap_n[2]-b[2])+(cap_n[3]-b[3]), 0);
      chk("R1 unused tags give no events",
          (loss_cnt[0]+loss_cnt[1]+ovf_cnt[0]+ovf_cnt[1]) - (l + o), 0);
      frag(1, 1'b1, 1'b0, 24'h5A6B7C);
      drain();
      chk("R1 tag 2 lands on lane 1", cap_n[1] - b[1], 3);
      chk("R1 tag 2 not on lane 0", cap_n[0] - b[0], 0);
      chk("R1 lane 1 first byte", int'(logb[1][b[1] % LOGD]), 'h5A);
   endtask

   task automatic t_no_packet();
      int b, l;
      restart(2);
      b = cap_n[2]; l = loss_cnt[2];
      frag(2, 1'b0, 1'b1, 24'h999999);
      frag(2, 1'b0, 1'b0, 24'h888888);
      drain();
      chk("R4 non-start words dropped", cap_n[2] - b, 0);
      chk("R4 dropped words raise no loss", loss_cnt[2] - l, 0);
   endtask

   task automatic t_seq();
      int l, l2;
      restart(0);
      l = loss_cnt[0];
      sq[0] = 3'd5;
      frag(0, 1'b1, 1'b0, 24'h000001);
      frag(0, 1'b0, 1'b0, 24'h000002);
      frag(0, 1'b0, 1'b0, 24'h000003);
      frag(0, 1'b0, 1'b0, 24'h000004);
      drain();
      chk("R7 in-order with wrap gives no loss", loss_cnt[0] - l, 0);
      sq[0] = sq[0] + 3'd2;
      frag(0, 1'b0, 1'b0, 24'h000005);
      drain();
      chk("R7 gap raises one loss pulse", loss_cnt[0] - l, 1);
      l2 = loss_cnt[0];
      frag(0, 1'b0, 1'b0, 24'h000006);
      drain();
      chk("R7 resumed order no further loss", loss_cnt[0] - l2, 0);
   endtask

   task automatic t_ovf();
      int o;
      o = ovf_cnt[0];
      frag(0, 1'b0, 1'b0, 24'h000007);
      drain();
      chk("R8 clear flag no pulse", ovf_cnt[0] - o, 0);
      frag(0, 1'b0, 1'b1, 24'h000008);
      drain();
      chk("R8 overflow flag pulses", ovf_cnt[0] - o, 1);
   endtask

   task automatic t_enable();
      int b3, b0, l0, e3;
      b3 = cap_n[3]; e3 = loss_cnt[3] + ovf_cnt[3];
      stream_en[3] = 1'b0;
      @(negedge clk);
      frag(3, 1'b1, 1'b1, 24'hABCDEF);
      drain();
      chk("R2 disabled stream emits nothing", cap_n[3] - b3, 0);
      chk("R2 disabled stream raises nothing", loss_cnt[3] + ovf_cnt[3] - e3, 0);
      stream_en[3] = 1'b1;
      @(negedge clk);
      restart(0);
      b0 = cap_n[0]; l0 = loss_cnt[0];
      frag(0, 1'b0, 1'b0, 24'h121212);
      drain();
      chk("R2 re-enabled stream has no packet in progress", cap_n[0] - b0, 0);
      sq[0] = sq[0] + 3'd4;
      frag(0, 1'b1, 1'b0, 24'h343434);
      drain();
      chk("R2 first word after enable skips sequence check", loss_cnt[0] - l0, 0);
      chk("R2 start word accepted after enable", cap_n[0] - b0, 3);
   endtask

   task automatic t_full_packet();
      int b;
      restart(1);
      b = cap_n[1];
      frag(1, 1'b1, 1'b0, 24'h102030);
      for (int k = 1; k < 62; k++) frag(1, 1'b0, 1'b0, 24'h405060);
      frag(1, 1'b0, 1'b0, 24'hDDEEFF);
      drain();
      chk("R6 packet length 188", cap_n[1] - b, 188);
      chk("R6 byte 186", int'(logb[1][(b + 186) % LOGD]), 'hDD);
      chk("R6 byte 187", int'(logb[1][(b + 187) % LOGD]), 'hEE);
      frag(1, 1'b0, 1'b0, 24'h777777);
      drain();
      chk("R6 word after packet end dropped", cap_n[1] - b, 188);
   endtask

   task automatic t_restart_mid();
      int b, sp;
      restart(1);
      b = cap_n[1]; sp = sop_cnt[1];
      frag(1, 1'b1, 1'b0, 24'h0A0B0C);
      for (int k = 0; k < 9; k++) frag(1, 1'b0, 1'b0, 24'h0D0E0F);
      frag(1, 1'b1, 1'b0, 24'h111213);
      for (int k = 1; k < 63; k++) frag(1, 1'b0, 1'b0, 24'h141516);
      drain();
      chk("R3 restart total bytes", cap_n[1] - b, 30 + 188);
      chk("R3 second start flagged", sop_cnt[1] - sp, 2);
      frag(1, 1'b0, 1'b0, 24'h171819);
      drain();
      chk("R3 restarted packet ends after 63 fragments", cap_n[1] - b, 30 + 188);
   endtask

   task automatic t_batch();
      int b, bc;
      restart(2);
      b = cap_n[2]; bc = batch_cnt[2];
      for (int p = 0; p < 21; p++) begin
         frag(2, 1'b1, 1'b0, 24'h202122);
         for (int k = 1; k < 62; k++) frag(2, 1'b0, 1'b0, 24'h232425);
         if (p == 20) begin
            drain();
            chk("R9 no batch before 21st packet ends", batch_cnt[2] - bc, 0);
         end
         frag(2, 1'b0, 1'b0, 24'h262728);
      end
      drain();
      chk("R9 one batch after 21 packets", batch_cnt[2] - bc, 1);
      chk("R9 batch marks final byte", batch_pos[2] - b, 21 * 188 - 1);
      chk("R9 other stream lanes unaffected", batch_cnt[1], 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ready();
      t_bytes();
      t_tags();
      t_no_packet();
      t_seq();
      t_ovf();
      t_enable();
      t_full_packet();
      t_restart_mid();
      t_batch();
      done = 1;
      finish_run();
   end

endmodule